// File: doc/BRIEF.md
# Serial Register Port for a Precision DAC

This block is the host-facing serial slave of a precision digital-to-analog converter. A host moves fixed 32-bit words over four wires: an active-low frame select, a serial clock, serial data in and serial data out. Each word carries a direction flag, a 7-bit register address and a 20-bit value, with four trailing pad bits. Words that write update a small register file. The register outputs drive the converter's code, its configuration, its clear code and its trigger controls.

Readback is split over two frames. A read frame only records which register was asked for. The answer leaves on the serial output during the following frame, in the same 32-bit layout, while the host sends its next word. When the chain input is high, the serial output instead replays the previous complete word unchanged. Several converters can then share one select line, each one passing the word it received down the chain.

The serial pins are brought into the system clock domain through a parameterized synchronizer. Edges are found there, so the serial clock must run well below the system clock.

Top module: `dacif_top`

## Requirements
- R1: After reset the register outputs read as follows, in the 24-bit field formed by data plus pad: config-1 = 004C80h, config-2 = 000040h, and code, clear code and trigger all zero. The serial output is 0 after reset.
- R2: A frame spans the time the select is low. The data input is sampled on each falling serial clock, MSB first. Bit 31 is the direction flag (0 = write, 1 = read), bits 30..24 are the address and bits 23..4 are the data.
- R3: A write frame with exactly 32 falling clocks updates the addressed register once the select rises. The map is 01h code, 02h config-1, 03h clear code, 04h trigger, 06h config-2. Register outputs change at no other time.
- R4: A frame with fewer or more than 32 falling clocks is discarded. It changes no register and records no read.
- R5: A completed read frame latches its address. During the next frame the serial output carries {1, address, register value, 0000}, MSB first. The first bit is valid once the select has fallen, and each rising serial clock advances one bit.
- R6: Bits 3..0 are ignored on writes and always return zero on reads.
- R7: Writes to 00h, to 05h or to any address above 06h change nothing. Reads of 00h or of any address above 06h return a zero data field.
- R8: Address 05h is read-only. A read of it returns the status input as it is at the start of the response frame.
- R9: With chain mode high, the serial output during a frame carries the previous complete 32-bit frame verbatim. Read requests get no reply in this mode: the pending read is dropped at the start of that frame.
- R10: In normal mode, a frame that does not follow a completed read shifts out all zeros.
- R11: While the select is high, the serial output settles at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host or next device |
| chain_en | input | 1 | 1 = replay previous frame on sdo |
| stat_in | input | 20 | Value returned by the read-only status address |
| dac_code | output | 20 | Converter code register |
| cfg1_q | output | 20 | Configuration register 1 |
| clear_code | output | 20 | Clear code register |
| trig_q | output | 20 | Trigger register |
| cfg2_q | output | 20 | Configuration register 2 |

## Verification
The assertions watch invariants that hold on every cycle. The two end-of-frame verdicts (kept and discarded) never fire together, and a kept frame lasts exactly one cycle. The falling-clock count stays bounded. The code and config-1 outputs move only in the cycle after a committed write. The serial output is zero once the select has been high for a cycle. Whether a register takes the right value, whether a response carries the right address and data, and whether chain mode replays the correct word all depend on a multi-frame history. Only the bench's frame sequences and its model can show those.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
   localparam int FRAME_W  = 32;
   localparam int ADDR_W   = 7;
   localparam int DATA_W   = 20;
   localparam int PAD_W    = 4;
   localparam int RW_POS   = FRAME_W - 1;
   localparam int ADDR_LSB = FRAME_W - 1 - ADDR_W;
   localparam int DATA_LSB = PAD_W;
   localparam int CNT_MAX  = FRAME_W + 1;
   localparam int CNT_W    = $clog2(CNT_MAX + 1);
   localparam int NUM_REGS = 7;
   localparam int IDX_W    = $clog2(NUM_REGS);

   localparam logic [ADDR_W-1:0] A_NOP  = 7'h00;
   localparam logic [ADDR_W-1:0] A_CODE = 7'h01;
   localparam logic [ADDR_W-1:0] A_CFG1 = 7'h02;
   localparam logic [ADDR_W-1:0] A_CLRV = 7'h03;
   localparam logic [ADDR_W-1:0] A_TRIG = 7'h04;
   localparam logic [ADDR_W-1:0] A_STAT = 7'h05;
   localparam logic [ADDR_W-1:0] A_CFG2 = 7'h06;

   function automatic logic [DATA_W-1:0] reset_val(input int idx);
      case (idx)
         2:       return 20'h004C8;
         6:       return 20'h00004;
         default: return '0;
      endcase
   endfunction

   function automatic bit writable(input int idx);
      return (idx == 1) || (idx == 2) || (idx == 3) || (idx == 4) || (idx == 6);
   endfunction
endpackage

// File: rtl/dacif_sync_edge.sv
module dacif_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic csn_i,
   input  logic sdi_i,
   output logic sdi_s,
   output logic cs_act,
   output logic cs_start,
   output logic cs_end,
   output logic sclk_fall,
   output logic sclk_rise
);
   logic sclk_s, csn_s;
   logic sclk_d, act_d;

   generate
      if (STAGES == 0) begin : g_direct
         assign sclk_s = sclk_i;
         assign csn_s  = csn_i;
         assign sdi_s  = sdi_i;
      end else begin : g_chain
         logic [STAGES:0] sc_c, cs_c, di_c;
         assign sc_c[0] = sclk_i;
         assign cs_c[0] = csn_i;
         assign di_c[0] = sdi_i;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sc_c[STAGES:1] <= '1;
               cs_c[STAGES:1] <= '1;
               di_c[STAGES:1] <= '0;
            end else begin
               sc_c[STAGES:1] <= sc_c[STAGES-1:0];
               cs_c[STAGES:1] <= cs_c[STAGES-1:0];
               di_c[STAGES:1] <= di_c[STAGES-1:0];
            end
         end
         assign sclk_s = sc_c[STAGES];
         assign csn_s  = cs_c[STAGES];
         assign sdi_s  = di_c[STAGES];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b1;
         act_d  <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         act_d  <= ~csn_s;
      end
   end

   assign cs_act    = ~csn_s;
   assign cs_start  = cs_act & ~act_d;
   assign cs_end    = ~cs_act & act_d;
   assign sclk_fall = ~sclk_s & sclk_d;
   assign sclk_rise = sclk_s & ~sclk_d;
endmodule

// File: rtl/dacif_frame_rx.sv
module dacif_frame_rx
   import dacif_pkg::*;
#(
   parameter int WORD_W = FRAME_W,
   parameter int CW     = CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sdi_s,
   input  logic              cs_act,
   input  logic              cs_start,
   input  logic              cs_end,
   input  logic              sclk_fall,
   output logic              frm_ok,
   output logic              frm_bad,
   output logic [WORD_W-1:0] frm_word,
   output logic [CW-1:0]     bit_cnt
);
   localparam logic [CW-1:0] FULL = CW'(WORD_W);
   localparam logic [CW-1:0] SAT  = CW'(WORD_W + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         frm_word <= '0;
         frm_ok   <= 1'b0;
         frm_bad  <= 1'b0;
      end else begin
         frm_ok  <= 1'b0;
         frm_bad <= 1'b0;
         if (cs_start) begin
            bit_cnt <= '0;
         end else if (cs_act && sclk_fall) begin
            frm_word <= {frm_word[WORD_W-2:0], sdi_s};
            if (bit_cnt != SAT) bit_cnt <= bit_cnt + 1'b1;
         end
         if (cs_end) begin
            frm_ok  <= (bit_cnt == FULL);
            frm_bad <= (bit_cnt != FULL);
         end
      end
   end
endmodule

// File: rtl/dacif_regfile.sv
module dacif_regfile
   import dacif_pkg::*;
#(
   parameter int AW = ADDR_W,
   parameter int DW = DATA_W,
   parameter int NR = NUM_REGS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] stat_in,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] regs [NR]
);
   localparam int IW = $clog2(NR);

   generate
      for (genvar i = 0; i < NR; i++) begin : g_reg
         if (writable(i)) begin : g_rw
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= DW'(reset_val(i));
               else if (wr_en && wr_addr == AW'(i))
                  q <= wr_data;
            end
            assign regs[i] = q;
         end else begin : g_ro
            assign regs[i] = '0;
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_STAT)
         rd_data = stat_in;
      else if (rd_addr < AW'(NR))
         rd_data = regs[rd_addr[IW-1:0]];
   end
endmodule

// File: rtl/dacif_tx.sv
module dacif_tx
   import dacif_pkg::*;
#(
   parameter int WORD_W = FRAME_W,
   parameter int AW     = ADDR_W,
   parameter int DW     = DATA_W,
   parameter int PW     = PAD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_start,
   input  logic              cs_end,
   input  logic              cs_act,
   input  logic              sclk_rise,
   input  logic              chain_en,
   input  logic              frm_ok,
   input  logic [WORD_W-1:0] frm_word,
   input  logic [DW-1:0]     rd_data,
   output logic [AW-1:0]     rd_addr,
   output logic              sdo
);
   logic              pend;
   logic [WORD_W-1:0] last_word;
   logic [WORD_W-1:0] sh;
   logic [WORD_W-1:0] load_val;

   always_comb begin
      if (chain_en)
         load_val = last_word;
      else if (pend)
         load_val = {1'b1, rd_addr, rd_data, {PW{1'b0}}};
      else
         load_val = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         rd_addr   <= '0;
         last_word <= '0;
         sh        <= '0;
      end else begin
         if (frm_ok) begin
            last_word <= frm_word;
            if (frm_word[WORD_W-1]) begin
               pend    <= 1'b1;
               rd_addr <= frm_word[WORD_W-2 -: AW];
            end
         end else if (cs_start) begin
            pend <= 1'b0;
         end
         if (cs_start)
            sh <= load_val;
         else if (cs_end)
            sh <= '0;
         else if (cs_act && sclk_rise)
            sh <= {sh[WORD_W-2:0], 1'b0};
      end
   end

   assign sdo = sh[WORD_W-1];
endmodule

// File: rtl/dacif_top.sv
module dacif_top
   import dacif_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              sdi,
   output logic              sdo,
   input  logic              chain_en,
   input  logic [DATA_W-1:0] stat_in,
   output logic [DATA_W-1:0] dac_code,
   output logic [DATA_W-1:0] cfg1_q,
   output logic [DATA_W-1:0] clear_code,
   output logic [DATA_W-1:0] trig_q,
   output logic [DATA_W-1:0] cfg2_q
);
   generate
      if (FRAME_W != 1 + ADDR_W + DATA_W + PAD_W) begin : g_bad_frame
         $error("frame fields do not fill the frame");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
   endgenerate

   logic               sdi_s, cs_act, cs_start, cs_end, sclk_fall, sclk_rise;
   logic               frm_ok, frm_bad, wr_en;
   logic [FRAME_W-1:0] frm_word;
   logic [CNT_W-1:0]   bit_cnt;
   logic [ADDR_W-1:0]  rd_addr;
   logic [DATA_W-1:0]  rd_data;
   logic [DATA_W-1:0]  regs [NUM_REGS];

   dacif_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(cs_n), .sdi_i(sdi),
      .sdi_s(sdi_s), .cs_act(cs_act), .cs_start(cs_start), .cs_end(cs_end),
      .sclk_fall(sclk_fall), .sclk_rise(sclk_rise)
   );

   dacif_frame_rx u_rx (
      .clk(clk), .rst_n(rst_n), .sdi_s(sdi_s), .cs_act(cs_act),
      .cs_start(cs_start), .cs_end(cs_end), .sclk_fall(sclk_fall),
      .frm_ok(frm_ok), .frm_bad(frm_bad), .frm_word(frm_word), .bit_cnt(bit_cnt)
   );

   assign wr_en = frm_ok & ~frm_word[RW_POS];

   dacif_regfile u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_addr(frm_word[ADDR_LSB +: ADDR_W]),
      .wr_data(frm_word[DATA_LSB +: DATA_W]),
      .rd_addr(rd_addr), .stat_in(stat_in), .rd_data(rd_data), .regs(regs)
   );

   dacif_tx u_tx (
      .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .cs_end(cs_end),
      .cs_act(cs_act), .sclk_rise(sclk_rise), .chain_en(chain_en),
      .frm_ok(frm_ok), .frm_word(frm_word), .rd_data(rd_data),
      .rd_addr(rd_addr), .sdo(sdo)
   );

   assign dac_code   = regs[int'(A_CODE)];
   assign cfg1_q     = regs[int'(A_CFG1)];
   assign clear_code = regs[int'(A_CLRV)];
   assign trig_q     = regs[int'(A_TRIG)];
   assign cfg2_q     = regs[int'(A_CFG2)];
endmodule

// File: rtl/dacif_checker.sv
module dacif_checker
   import dacif_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              cs_act,
   input logic              frm_ok,
   input logic              frm_bad,
   input logic              wr_en,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic [DATA_W-1:0] dac_code,
   input logic [DATA_W-1:0] cfg1_q,
   input logic              sdo
);
   // R4: a frame ends as kept or discarded, never both
   a_r4_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({frm_ok, frm_bad}));

   // R4: falling-clock count saturates one past a full frame
   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(CNT_MAX));

   // R5: a kept frame is reported for one cycle only
   a_r5_ok_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frm_ok |=> !frm_ok);

   // R3: code register moves only after a committed write
   a_r3_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(dac_code));

   // R3: config-1 moves only after a committed write
   a_r3_cfg1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg1_q));

   // R11: output at rest once select has been high a cycle
   a_r11_sdo_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_act && $past(!cs_act)) |-> !sdo);
endmodule

bind dacif_top dacif_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .frm_ok(frm_ok),
   .frm_bad(frm_bad), .wr_en(wr_en), .bit_cnt(bit_cnt),
   .dac_code(dac_code), .cfg1_q(cfg1_q), .sdo(sdo)
);

// File: tb/tb_dacif_top.sv
module tb_dacif_top;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b1;
   logic        cs_n = 1'b1;
   logic        sdi = 1'b0;
   logic        sdo;
   logic        chain_en = 1'b0;
   logic [19:0] stat_in = 20'h0;
   logic [19:0] dac_code, cfg1_q, clear_code, trig_q, cfg2_q;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [19:0] m [8];
   logic        pv;
   logic [6:0]  pa;
   logic [31:0] prev;

   always #5 clk = ~clk;

   dacif_top dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
      .chain_en(chain_en), .stat_in(stat_in), .dac_code(dac_code),
      .cfg1_q(cfg1_q), .clear_code(clear_code), .trig_q(trig_q), .cfg2_q(cfg2_q)
   );

   function automatic logic [19:0] rdv(input logic [6:0] a);
      if (a == 7'h05) return stat_in;
      if (a >= 7'h01 && a <= 7'h06) return m[a[2:0]];
      return 20'h0;
   endfunction

   function automatic bit wr_ok(input logic [6:0] a);
      return (a >= 7'h01 && a <= 7'h06 && a != 7'h05);
   endfunction

   task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic check_ports(input string tag);
      check(tag, {28'h0, dac_code, cfg1_q, clear_code, trig_q, cfg2_q},
            {28'h0, m[1], m[2], m[3], m[4], m[6]});
   endtask

   task automatic xfer(input logic [31:0] w, input int nb, output logic [31:0] got);
      got = '0;
      cs_n = 1'b0;
      for (int i = 0; i < nb; i++) begin
         sdi = (i < 32) ? w[31-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         if (i < 32) got[31-i] = sdo;
         sclk = 1'b0;
         repeat (HALF) @(negedge clk);
         sclk = 1'b1;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      sdi = 1'b0;
      repeat (3*HALF) @(negedge clk);
   endtask

   task automatic frame(input logic [31:0] w, input int nb, input string tag);
      logic [31:0] exp, got, mask;
      if (chain_en) exp = prev;
      else if (pv)  exp = {1'b1, pa, rdv(pa), 4'h0};
      else          exp = 32'h0;
      pv = 1'b0;
      mask = (nb >= 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> nb);
      xfer(w, nb, got);
      check({tag, " sdo word"}, {96'h0, got & mask}, {96'h0, exp & mask});
      check("R11 sdo idle", {127'h0, sdo}, 128'h0);
      if (nb == 32) begin
         prev = w;
         if (w[31]) begin
            pv = 1'b1;
            pa = w[30:24];
         end else if (wr_ok(w[30:24])) begin
            m[w[26:24]] = w[23:4];
         end
      end
      check_ports({tag, " ports"});
   endtask

   function automatic logic [31:0] mk(input bit rd, input logic [6:0] a,
                                      input logic [19:0] d, input logic [3:0] p);
      return {rd, a, d, p};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1 got timeout exp finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 8; i++) m[i] = 20'h0;
      m[2] = 20'h004C8;
      m[6] = 20'h00004;
      pv = 1'b0; pa = '0; prev = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset state
      check_ports("R1 reset regs");
      check("R1 reset sdo", {127'h0, sdo}, 128'h0);

      // R1 R2 R5: read config-1 and config-2 reset values
      frame(mk(1, 7'h02, 20'h0, 4'h0), 32, "R2 read cfg1");
      frame(mk(1, 7'h06, 20'h0, 4'h0), 32, "R1 cfg1 reply");
      frame(mk(0, 7'h00, 20'h0, 4'h0), 32, "R1 cfg2 reply");
      // R10 frame after non-read shifts zeros
      frame(mk(0, 7'h00, 20'h0, 4'h0), 32, "R10 no reply");

      // R3 R6: write with pad set, read back with zero pad
      frame(mk(0, 7'h01, 20'hABCDE, 4'hF), 32, "R3 write code");
      frame(mk(1, 7'h01, 20'h0, 4'hA), 32, "R6 read code");
      frame(mk(0, 7'h00, 20'h0, 4'h0), 32, "R6 pad zero reply");

      // R4 short and long frames are dropped
      frame(mk(0, 7'h01, 20'h12345, 4'h0), 20, "R4 short write");
      frame(mk(0, 7'h03, 20'h54321, 4'h0), 33, "R4 long write");
      frame(mk(1, 7'h03, 20'h0, 4'h0), 31, "R4 short read");
      frame(mk(0, 7'h00, 20'h0, 4'h0), 32, "R4 no reply");

      // R7 writes to nop, status and unmapped addresses
      frame(mk(0, 7'h00, 20'hFFFFF, 4'h0), 32, "R7 nop write");
      frame(mk(0, 7'h05, 20'hFFFFF, 4'h0), 32, "R7 status write");
      frame(mk(0, 7'h55, 20'hFFFFF, 4'h0), 32, "R7 unmapped write");
      frame(mk(1, 7'h40, 20'h0, 4'h0), 32, "R7 unmapped read");
      frame(mk(1, 7'h00, 20'h0, 4'h0), 32, "R7 unmapped reply");
      frame(mk(0, 7'h00, 20'h0, 4'h0), 32, "R7 nop reply");

      // R8 status readback
      stat_in = 20'h9A5C3;
      frame(mk(1, 7'h05, 20'h0, 4'h0), 32, "R8 read status");
      stat_in = 20'h13579;
      frame(mk(0, 7'h00, 20'h0, 4'h0), 32, "R8 status reply");

      // R9 chain mode replays previous frame, drops reads
      chain_en = 1'b1;
      frame(mk(0, 7'h04, 20'h0F0F0, 4'h3), 32, "R9 chain first");
      frame(mk(1, 7'h04, 20'h11111, 4'h5), 32, "R9 chain second");
      frame(mk(0, 7'h03, 20'h22222, 4'h0), 32, "R9 chain third");
      chain_en = 1'b0;
      frame(mk(0, 7'h00, 20'h0, 4'h0), 32, "R9 read dropped");

      // random mix
      for (int k = 0; k < 120; k++) begin
         logic [6:0] a;
         int nb, sel;
         sel = $urandom_range(0, 9);
         a = (sel < 8) ? 7'($urandom_range(0, 7)) : 7'($urandom);
         nb = ($urandom_range(0, 7) == 0) ? $urandom_range(1, 34) : 32;
         chain_en = ($urandom_range(0, 5) == 0);
         stat_in = 20'($urandom);
         frame(mk(1'($urandom), a, 20'($urandom), 4'($urandom)), nb, "R5 R3 random");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule